// File: doc/BRIEF.md
# RTC alarm match and repeat controller

This block watches a running BCD calendar time and issues a single-cycle alarm pulse when the programmed alarm time matches. A coded period selects which time fields take part in the comparison. The two shortest periods fire on every half-second or one-second strobe. Longer periods compare progressively more digits, from the seconds ones digit up to the month. Time fields are only looked at when a strobe arrives, so each qualifying strobe yields at most one pulse.

Software sets up the block through a 16-bit control word and a windowed data port. The control word holds the enable, the chime flag, the period code, the window pointer and a repeat counter. The three alarm value words are reached one at a time through the data port. The slot is chosen by the pointer, which steps down by one after each access, so a burst of accesses starting at pointer 2 walks from the month/day word down to the minutes/seconds word.

Each alarm event decrements the repeat counter. When the counter is at zero and chime is off, the counter holds at zero and the event turns the enable off. When chime is on, the counter wraps to 0xFF and the alarm keeps running.

Top module: `rtc_alarm_unit`

## Requirements
- R1: After a synchronous reset, the control word reads 0x0000, all three alarm value words are zero, and `alarm_pulse` is low.
- R2: Control word layout: bit 15 is the enable, bit 14 is chime, bits 13:10 are the period code, bits 9:8 are the window pointer and bits 7:0 are the repeat count. A write to the control word replaces all fields, and this write takes priority over any event or pointer step in the same cycle.
- R3: Period code 0 fires on `tick_half` only. Period code 1 fires on `tick_sec` only. Neither code compares any time digits.
- R4: For codes 2 to 9, the fields that must equal the stored alarm values are as follows. Code 2 (every 10 s) compares the seconds low nibble. Code 3 (every minute) compares the seconds. Code 4 (every 10 min) compares the seconds and the minutes low nibble. Code 5 (hourly) compares the seconds and minutes. Code 6 (daily) adds the hours. Code 7 (weekly) adds the weekday. Code 8 (monthly) compares seconds, minutes, hours and day, without the weekday. Code 9 (yearly) adds the month. All of these codes are evaluated on `tick_sec`.
- R5: Period codes 10 to 15 never produce an event, even when every field matches.
- R6: While the enable bit is 0, no event occurs and `alarm_pulse` stays low.
- R7: Each event decrements the repeat count by one. With chime clear, a count of 0x00 stays at 0x00.
- R8: With chime set, an event at a count of 0x00 loads 0xFF, and the enable stays set.
- R9: An event at a count of 0x00 with chime clear clears the enable. Every other event leaves the enable set.
- R10: Window slots are addressed by the pointer. Pointer 0 holds {minutes, seconds}, pointer 1 holds {weekday, hours} and pointer 2 holds {month, day}, each as two BCD bytes with the upper field in bits 15:8. Pointer 3 reads 0x0000 and ignores writes. A read returns the slot's data on `win_rdata` in the cycle after `win_re`.
- R11: Each cycle with `win_re` or `win_we` (or both) decrements the pointer by one. At 0 the pointer stays at 0.
- R12: `alarm_pulse` rises in the cycle after the strobe that caused the event and lasts exactly one cycle.
- R13: A yearly alarm set to month 0x02 and day 0x29 fires only when the current date is 02/29.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 16 | Control word write data |
| cfg_rdata | output | 16 | Current control word |
| win_we | input | 1 | Window write strobe |
| win_re | input | 1 | Window read strobe |
| win_wdata | input | 16 | Window write data |
| win_rdata | output | 16 | Registered window read data |
| tick_half | input | 1 | Half-second strobe |
| tick_sec | input | 1 | One-second strobe |
| now_sec | input | 8 | Current seconds, BCD |
| now_min | input | 8 | Current minutes, BCD |
| now_hour | input | 8 | Current hours, BCD |
| now_wday | input | 8 | Current weekday, BCD |
| now_day | input | 8 | Current day of month, BCD |
| now_month | input | 8 | Current month, BCD |
| alarm_pulse | output | 1 | One-cycle alarm event pulse |

## Verification
The assertions check the following on every cycle:
- reserved period codes never produce a match;
- a pulse follows a strobe and an enabled control word;
- the repeat counter holds at zero or wraps on its final event, and the enable clears when it should;
- the pointer steps down on each access and stops at zero.

Only the bench scenarios can show which digits each period code actually compares, the window slot mapping including the dead fourth slot, the February 29 yearly case, and the interaction between a control write and an event in the same cycle. The bench shows these by comparing against its reference model and running directed date patterns.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  localparam int unsigned CW_W   = 16;
  localparam int unsigned CODE_W = 4;
  localparam int unsigned CNT_W  = 8;
  localparam int unsigned PTR_W  = 2;

  localparam logic [CODE_W-1:0] CODE_HALF  = 4'd0;
  localparam logic [CODE_W-1:0] CODE_SEC   = 4'd1;
  localparam logic [CODE_W-1:0] CODE_10S   = 4'd2;
  localparam logic [CODE_W-1:0] CODE_MIN   = 4'd3;
  localparam logic [CODE_W-1:0] CODE_10M   = 4'd4;
  localparam logic [CODE_W-1:0] CODE_HOUR  = 4'd5;
  localparam logic [CODE_W-1:0] CODE_DAY   = 4'd6;
  localparam logic [CODE_W-1:0] CODE_WEEK  = 4'd7;
  localparam logic [CODE_W-1:0] CODE_MONTH = 4'd8;
  localparam logic [CODE_W-1:0] CODE_YEAR  = 4'd9;

  typedef struct packed {
    logic [7:0] month;
    logic [7:0] day;
    logic [7:0] wday;
    logic [7:0] hour;
    logic [7:0] min;
    logic [7:0] sec;
  } bcd_time_t;

  typedef struct packed {
    logic need_sec_lo;
    logic need_sec;
    logic need_min_lo;
    logic need_min;
    logic need_hour;
    logic need_wday;
    logic need_day;
    logic need_month;
    logic legal;
  } field_sel_t;
endpackage

// File: rtl/alarm_match.sv
module alarm_match
  import alarm_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [CODE_W-1:0]     code,
  input  bcd_time_t             now,
  input  logic [DW-1:0]         slot_ms,
  input  logic [DW-1:0]         slot_wh,
  input  logic [DW-1:0]         slot_md,
  output logic                  match
);
  localparam int unsigned HB = DW / 2;

  field_sel_t sel;

  always_comb begin
    sel = '0;
    sel.legal = 1'b1;
    case (code)
      CODE_HALF, CODE_SEC: ;
      CODE_10S:   sel.need_sec_lo = 1'b1;
      CODE_MIN:   sel.need_sec = 1'b1;
      CODE_10M:   begin sel.need_sec = 1'b1; sel.need_min_lo = 1'b1; end
      CODE_HOUR:  begin sel.need_sec = 1'b1; sel.need_min = 1'b1; end
      CODE_DAY:   begin sel.need_sec = 1'b1; sel.need_min = 1'b1; sel.need_hour = 1'b1; end
      CODE_WEEK:  begin sel.need_sec = 1'b1; sel.need_min = 1'b1; sel.need_hour = 1'b1;
                        sel.need_wday = 1'b1; end
      CODE_MONTH: begin sel.need_sec = 1'b1; sel.need_min = 1'b1; sel.need_hour = 1'b1;
                        sel.need_day = 1'b1; end
      CODE_YEAR:  begin sel.need_sec = 1'b1; sel.need_min = 1'b1; sel.need_hour = 1'b1;
                        sel.need_day = 1'b1; sel.need_month = 1'b1; end
      default:    sel.legal = 1'b0;
    endcase
  end

  logic eq_sec_lo, eq_sec, eq_min_lo, eq_min, eq_hour, eq_wday, eq_day, eq_month;

  assign eq_sec_lo = now.sec[3:0]  == slot_ms[3:0];
  assign eq_sec    = now.sec       == slot_ms[HB-1:0];
  assign eq_min_lo = now.min[3:0]  == slot_ms[HB+3:HB];
  assign eq_min    = now.min       == slot_ms[DW-1:HB];
  assign eq_hour   = now.hour      == slot_wh[HB-1:0];
  assign eq_wday   = now.wday      == slot_wh[DW-1:HB];
  assign eq_day    = now.day       == slot_md[HB-1:0];
  assign eq_month  = now.month     == slot_md[DW-1:HB];

  assign match = sel.legal
               & (~sel.need_sec_lo | eq_sec_lo)
               & (~sel.need_sec    | eq_sec)
               & (~sel.need_min_lo | eq_min_lo)
               & (~sel.need_min    | eq_min)
               & (~sel.need_hour   | eq_hour)
               & (~sel.need_wday   | eq_wday)
               & (~sel.need_day    | eq_day)
               & (~sel.need_month  | eq_month);

  AST_RESERVED_SILENT: assert property (@(posedge clk) disable iff (rst)
    (code > CODE_YEAR) |-> !match); // R5
endmodule

// File: rtl/alarm_window.sv
module alarm_window
  import alarm_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter int unsigned PW = PTR_W
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       ptr_load,
  input  logic [PW-1:0]              ptr_din,
  input  logic                       acc_we,
  input  logic                       acc_re,
  input  logic [DW-1:0]              wdata,
  output logic [DW-1:0]              rdata,
  output logic [PW-1:0]              ptr,
  output logic [(2**PW)-2:0][DW-1:0] slots
);
  localparam int unsigned NUM_SLOT = (2 ** PW) - 1;

  logic [DW-1:0] mem [NUM_SLOT];
  logic [DW-1:0] rd_sel;

  for (genvar g = 0; g < NUM_SLOT; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        mem[g] <= '0;
      end else if (acc_we && ptr == PW'(g)) begin
        mem[g] <= wdata;
      end
    end
    assign slots[g] = mem[g];
  end

  always_comb begin
    rd_sel = '0;
    for (int i = 0; i < NUM_SLOT; i++) begin
      if (ptr == PW'(i)) rd_sel = mem[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
      ptr   <= '0;
    end else begin
      if (acc_re) rdata <= rd_sel;
      if (ptr_load) begin
        ptr <= ptr_din;
      end else if ((acc_we || acc_re) && ptr != '0) begin
        ptr <= ptr - 1'b1;
      end
    end
  end

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
    ((acc_we || acc_re) && !ptr_load && ptr != '0) |=> (ptr == $past(ptr) - 1'b1)); // R11
  AST_PTR_FLOOR: assert property (@(posedge clk) disable iff (rst)
    ((acc_we || acc_re) && !ptr_load && ptr == '0) |=> (ptr == '0)); // R11
endmodule

// File: rtl/alarm_ctrl.sv
module alarm_ctrl
  import alarm_pkg::*;
#(
  parameter int unsigned CW = CNT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic              en_din,
  input  logic              chime_din,
  input  logic [CODE_W-1:0] code_din,
  input  logic [CW-1:0]     cnt_din,
  input  logic              tick_half,
  input  logic              tick_sec,
  input  logic              match,
  output logic              en_q,
  output logic              chime_q,
  output logic [CODE_W-1:0] code_q,
  output logic [CW-1:0]     cnt_q,
  output logic              pulse_q
);
  logic strobe, fire, last_shot;

  assign strobe    = (code_q == CODE_HALF) ? tick_half : tick_sec;
  assign fire      = en_q & strobe & match;
  assign last_shot = (cnt_q == '0) & ~chime_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= 1'b0;
      chime_q <= 1'b0;
      code_q  <= '0;
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= fire;
      if (cfg_we) begin
        en_q    <= en_din;
        chime_q <= chime_din;
        code_q  <= code_din;
        cnt_q   <= cnt_din;
      end else if (fire) begin
        if (last_shot) en_q <= 1'b0;
        else           cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  AST_PULSE_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    pulse_q |-> $past(en_q)); // R6
  AST_PULSE_AFTER_TICK: assert property (@(posedge clk) disable iff (rst)
    pulse_q |-> $past(tick_half || tick_sec)); // R12
  AST_LAST_SHOT: assert property (@(posedge clk) disable iff (rst)
    (fire && !cfg_we && cnt_q == '0 && !chime_q) |=> (!en_q && cnt_q == '0)); // R9
  AST_CHIME_WRAP: assert property (@(posedge clk) disable iff (rst)
    (fire && !cfg_we && cnt_q == '0 && chime_q) |=> (en_q && cnt_q == {CW{1'b1}})); // R8
endmodule

// File: rtl/rtc_alarm_unit.sv
module rtc_alarm_unit
  import alarm_pkg::*;
#(
  parameter int unsigned DW = CW_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [DW-1:0] cfg_wdata,
  output logic [DW-1:0] cfg_rdata,
  input  logic          win_we,
  input  logic          win_re,
  input  logic [DW-1:0] win_wdata,
  output logic [DW-1:0] win_rdata,
  input  logic          tick_half,
  input  logic          tick_sec,
  input  logic [7:0]    now_sec,
  input  logic [7:0]    now_min,
  input  logic [7:0]    now_hour,
  input  logic [7:0]    now_wday,
  input  logic [7:0]    now_day,
  input  logic [7:0]    now_month,
  output logic          alarm_pulse
);
  localparam int unsigned NSLOT  = (2 ** PTR_W) - 1;
  localparam int unsigned CODE_LO = PTR_W + CNT_W;

  logic                    en_q, chime_q, match;
  logic [CODE_W-1:0]       code_q;
  logic [CNT_W-1:0]        cnt_q;
  logic [PTR_W-1:0]        ptr_q;
  logic [NSLOT-1:0][DW-1:0] slots;
  bcd_time_t               now;

  assign now = '{month: now_month, day: now_day, wday: now_wday,
                 hour: now_hour, min: now_min, sec: now_sec};

  alarm_window #(.DW(DW), .PW(PTR_W)) u_win (
    .clk      (clk),
    .rst      (rst),
    .ptr_load (cfg_we),
    .ptr_din  (cfg_wdata[CODE_LO-1:CNT_W]),
    .acc_we   (win_we),
    .acc_re   (win_re),
    .wdata    (win_wdata),
    .rdata    (win_rdata),
    .ptr      (ptr_q),
    .slots    (slots)
  );

  alarm_match #(.DW(DW)) u_match (
    .clk     (clk),
    .rst     (rst),
    .code    (code_q),
    .now     (now),
    .slot_ms (slots[0]),
    .slot_wh (slots[1]),
    .slot_md (slots[2]),
    .match   (match)
  );

  alarm_ctrl #(.CW(CNT_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .en_din    (cfg_wdata[DW-1]),
    .chime_din (cfg_wdata[DW-2]),
    .code_din  (cfg_wdata[DW-3:CODE_LO]),
    .cnt_din   (cfg_wdata[CNT_W-1:0]),
    .tick_half (tick_half),
    .tick_sec  (tick_sec),
    .match     (match),
    .en_q      (en_q),
    .chime_q   (chime_q),
    .code_q    (code_q),
    .cnt_q     (cnt_q),
    .pulse_q   (alarm_pulse)
  );

  assign cfg_rdata = {en_q, chime_q, code_q, ptr_q, cnt_q};
endmodule

// File: tb/sim_rtc_alarm_unit.sv
module sim_rtc_alarm_unit;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst = 1;
  logic cfg_we = 0, win_we = 0, win_re = 0, tick_half = 0, tick_sec = 0;
  logic [15:0] cfg_wdata = 0, win_wdata = 0;
  logic [15:0] cfg_rdata, win_rdata;
  logic [7:0] now_sec = 0, now_min = 0, now_hour = 0, now_wday = 0, now_day = 0, now_month = 0;
  logic alarm_pulse;

  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_alarm_unit u0 (.*);

  // behavioural reference
  bit m_en, m_ch, m_pulse;
  int m_code, m_ptr, m_cnt;
  int m_win [3];
  int m_rd;

  function automatic bit ref_hit();
    int s = now_sec, mi = now_min, h = now_hour, wd = now_wday, d = now_day, mo = now_month;
    bit ok = 1;
    if (m_code > 9) return 0;
    if (m_code == 2) ok = (s % 16) == (m_win[0] % 16);
    if (m_code >= 3) ok = ok && s == (m_win[0] % 256);
    if (m_code == 4) ok = ok && (mi % 16) == ((m_win[0] / 256) % 16);
    if (m_code >= 5) ok = ok && mi == m_win[0] / 256;
    if (m_code >= 6) ok = ok && h == (m_win[1] % 256);
    if (m_code == 7) ok = ok && wd == m_win[1] / 256;
    if (m_code >= 8) ok = ok && d == (m_win[2] % 256);
    if (m_code == 9) ok = ok && mo == m_win[2] / 256;
    return ok && m_en && (m_code == 0 ? tick_half : tick_sec);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_en = 0; m_ch = 0; m_code = 0; m_ptr = 0; m_cnt = 0; m_pulse = 0; m_rd = 0;
      foreach (m_win[i]) m_win[i] = 0;
    end else begin
      bit hit;
      hit = ref_hit();
      if (win_re) m_rd = (m_ptr < 3) ? m_win[m_ptr] : 0;
      if (win_we && m_ptr < 3) m_win[m_ptr] = win_wdata;
      if (cfg_we) begin
        m_en = cfg_wdata[15]; m_ch = cfg_wdata[14];
        m_code = cfg_wdata[13:10]; m_ptr = cfg_wdata[9:8]; m_cnt = cfg_wdata[7:0];
      end else begin
        if ((win_we || win_re) && m_ptr > 0) m_ptr--;
        if (hit) begin
          if (m_cnt == 0 && !m_ch) m_en = 0;
          else m_cnt = (m_cnt + 255) % 256;
        end
      end
      m_pulse = hit;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      chk("R12 pulse vs model", alarm_pulse, m_pulse);
      chk("R2 control word vs model",
          cfg_rdata, {m_en, m_ch, 4'(m_code), 2'(m_ptr), 8'(m_cnt)});
      chk("R10 read data vs model", win_rdata, 16'(m_rd));
    end
  end

  task automatic wr_cfg(logic [15:0] v);
    @(negedge clk); cfg_we = 1; cfg_wdata = v;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic wr_win(logic [15:0] v);
    @(negedge clk); win_we = 1; win_wdata = v;
    @(negedge clk); win_we = 0;
  endtask

  task automatic rd_win(output logic [15:0] v);
    @(negedge clk); win_re = 1;
    @(negedge clk); win_re = 0; v = win_rdata;
  endtask

  task automatic strobe(bit h, bit s, output bit got);
    @(negedge clk); tick_half = h; tick_sec = s;
    @(negedge clk); tick_half = 0; tick_sec = 0; got = alarm_pulse;
    @(negedge clk);
    chk("R12 pulse single cycle", alarm_pulse, 0);
  endtask

  task automatic set_time(logic [7:0] mo, dy, wd, hr, mi, se);
    now_month = mo; now_day = dy; now_wday = wd; now_hour = hr; now_min = mi; now_sec = se;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R12 watchdog expired: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v;
    bit got;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 control word at reset", cfg_rdata, 16'h0000);
    chk("R1 pulse at reset", alarm_pulse, 0);
    rd_win(v); chk("R1 slot0 at reset", v, 16'h0000);

    // fill slots from pointer 2 downward
    wr_cfg(16'h0200);
    chk("R2 pointer field", cfg_rdata, 16'h0200);
    wr_win(16'h1225);
    chk("R11 pointer step", cfg_rdata[9:8], 2'd1);
    wr_win(16'h0310);
    wr_win(16'h3045);
    chk("R11 pointer at zero", cfg_rdata[9:8], 2'd0);
    rd_win(v);
    chk("R10 slot0 minutes/seconds", v, 16'h3045);
    chk("R11 pointer floor", cfg_rdata[9:8], 2'd0);
    wr_cfg(16'h0200);
    rd_win(v); chk("R10 slot2 month/day", v, 16'h1225);
    rd_win(v); chk("R10 slot1 weekday/hours", v, 16'h0310);
    // dead slot
    wr_cfg(16'h0300);
    rd_win(v); chk("R10 slot3 reads zero", v, 16'h0000);
    wr_cfg(16'h0300);
    wr_win(16'hFFFF);
    rd_win(v); chk("R10 slot3 write ignored, slot2 intact", v, 16'h1225);

    // half-second code with repeat 2
    wr_cfg(16'h8002);
    strobe(0, 1, got); chk("R3 code0 ignores sec tick", got, 0);
    strobe(1, 0, got); chk("R3 code0 fires on half tick", got, 1);
    chk("R7 count decrement", cfg_rdata, 16'h8001);
    strobe(1, 0, got);
    chk("R7 count reaches zero", cfg_rdata, 16'h8000);
    strobe(1, 0, got); chk("R9 final event still pulses", got, 1);
    chk("R9 enable cleared, count held", cfg_rdata, 16'h0000);
    strobe(1, 0, got); chk("R6 disabled no pulse", got, 0);

    // chime wrap
    wr_cfg(16'hC400);
    strobe(1, 0, got); chk("R3 code1 ignores half tick", got, 0);
    strobe(0, 1, got); chk("R3 code1 fires on sec tick", got, 1);
    chk("R8 wrap to FF with enable kept", cfg_rdata, 16'hC4FF);

    // field matching: alarm Dec 25, weekday 3, 10:30:45
    set_time(8'h12, 8'h25, 8'h03, 8'h10, 8'h30, 8'h45);
    for (int m = 2; m <= 9; m++) begin
      wr_cfg(16'h8005 | 16'(m << 10));
      strobe(0, 1, got); chk("R4 full match fires", got, 1);
    end
    wr_cfg(16'h8805);
    set_time(8'h12, 8'h25, 8'h03, 8'h10, 8'h30, 8'h35);
    strobe(0, 1, got); chk("R4 code2 ones digit only", got, 1);
    set_time(8'h12, 8'h25, 8'h03, 8'h10, 8'h30, 8'h44);
    strobe(0, 1, got); chk("R4 code2 ones mismatch", got, 0);
    wr_cfg(16'h9005);
    set_time(8'h12, 8'h25, 8'h03, 8'h10, 8'h20, 8'h45);
    strobe(0, 1, got); chk("R4 code4 minute tens ignored", got, 1);
    set_time(8'h12, 8'h25, 8'h03, 8'h10, 8'h31, 8'h45);
    strobe(0, 1, got); chk("R4 code4 minute ones mismatch", got, 0);
    wr_cfg(16'h9805);
    set_time(8'h12, 8'h25, 8'h03, 8'h11, 8'h30, 8'h45);
    strobe(0, 1, got); chk("R4 code6 hour mismatch", got, 0);
    wr_cfg(16'h9C05);
    set_time(8'h12, 8'h24, 8'h03, 8'h10, 8'h30, 8'h45);
    strobe(0, 1, got); chk("R4 code7 day ignored", got, 1);
    set_time(8'h12, 8'h25, 8'h04, 8'h10, 8'h30, 8'h45);
    strobe(0, 1, got); chk("R4 code7 weekday mismatch", got, 0);
    wr_cfg(16'hA005);
    strobe(0, 1, got); chk("R4 code8 weekday ignored", got, 1);
    set_time(8'h12, 8'h24, 8'h03, 8'h10, 8'h30, 8'h45);
    strobe(0, 1, got); chk("R4 code8 day mismatch", got, 0);
    wr_cfg(16'hA405);
    set_time(8'h11, 8'h25, 8'h03, 8'h10, 8'h30, 8'h45);
    strobe(0, 1, got); chk("R4 code9 month mismatch", got, 0);

    // reserved codes
    set_time(8'h12, 8'h25, 8'h03, 8'h10, 8'h30, 8'h45);
    for (int m = 10; m <= 15; m++) begin
      wr_cfg(16'h8005 | 16'(m << 10));
      strobe(1, 1, got); chk("R5 reserved code silent", got, 0);
    end
    wr_cfg(16'h0405);
    strobe(0, 1, got); chk("R6 enable off no pulse", got, 0);

    // leap day yearly alarm
    wr_cfg(16'h0200);
    wr_win(16'h0229);
    wr_cfg(16'hA405);
    set_time(8'h02, 8'h28, 8'h03, 8'h10, 8'h30, 8'h45);
    strobe(0, 1, got); chk("R13 Feb 28 no pulse", got, 0);
    set_time(8'h03, 8'h01, 8'h03, 8'h10, 8'h30, 8'h45);
    strobe(0, 1, got); chk("R13 Mar 1 no pulse", got, 0);
    set_time(8'h02, 8'h29, 8'h03, 8'h10, 8'h30, 8'h45);
    strobe(0, 1, got); chk("R13 Feb 29 fires", got, 1);

    // control write wins over same-cycle event
    @(negedge clk); tick_sec = 1; cfg_we = 1; cfg_wdata = 16'h8413;
    @(negedge clk); tick_sec = 0; cfg_we = 0;
    chk("R2 write priority over event", cfg_rdata, 16'h8413);

    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule